// File: doc/BRIEF.md
# Released-Key Digit Decoder

This block sits behind a PS/2 byte receiver that has already assembled each 8-bit scan-code byte (scan code set 2) and marks it with a one-cycle strobe. It watches the byte stream for the key-release marker (0xF0). It produces one result per physical keystroke, on the release, so the make codes that a held key resends never reach the output.

Each released key is turned into a 4-bit BCD digit. The main-row digit keys and, when enabled, the numeric keypad digits give their value. Every other key gives zero. The Enter key also raises an enter flag. A one-cycle `done_o` pulse marks each result, and the digit and enter flag stay registered until the next result.

Top module: `kbd_release_digit`

## Requirements
- R1: A byte that arrives while no release is pending produces no `done_o` pulse and leaves `digit_o` and `enter_o` unchanged. This covers typematic make-code repeats.
- R2: After a 0xF0 byte, the next byte other than 0xE0 or 0xF0 is reported: `done_o` is high in the cycle after that byte's strobe. The main-row codes map as 0x45→0, 0x16→1, 0x1E→2, 0x26→3, 0x25→4, 0x2E→5, 0x36→6, 0x3D→7, 0x3E→8, 0x46→9.
- R3: With `KEYPAD_EN`=1 (the default), the keypad codes map as 0x70→0, 0x69→1, 0x72→2, 0x7A→3, 0x6B→4, 0x73→5, 0x74→6, 0x6C→7, 0x75→8, 0x7D→9.
- R4: Any other released code reports `digit_o`=0 and `enter_o`=0.
- R5: A released 0x5A reports `enter_o`=1 with `digit_o`=0.
- R6: An 0xE0 byte neither sets nor clears a pending release. Both the order E0,F0,5A and the order F0,E0,5A report Enter once.
- R7: The pending release clears after each report, so a following byte alone produces no report.
- R8: `done_o` is high for exactly one cycle per report.
- R9: `digit_o` and `enter_o` change only together with `done_o` and hold their values between reports.
- R10: A synchronous active-high `rst_i` clears `done_o`, `digit_o`, `enter_o` and any pending release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| byte_valid_i | input | 1 | One-cycle strobe marking a completed scan-code byte |
| byte_i | input | 8 | Scan-code byte, valid with the strobe |
| done_o | output | 1 | One-cycle pulse: a released key is reported |
| digit_o | output | 4 | BCD digit of the last released key |
| enter_o | output | 1 | Last released key was Enter |

## Verification
The assertions assume that a report can only follow a strobed byte, and that two reports are always separated by at least one 0xF0 byte. This means `done_o` can never be high in two consecutive cycles. The receiver upstream naturally gives this, because every byte is strobed once and every release needs its own 0xF0 marker. The stimulus drives each byte as a single one-cycle strobe and never holds `byte_valid_i` high across bytes. It includes back-to-back strobes, held-key repeats, prefix reorderings and a reset while a release is pending.

// File: rtl/kbd_digit_pkg.sv
package kbd_digit_pkg;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned DIGIT_W = 4;

  localparam logic [CODE_W-1:0] CODE_RELEASE = 8'hF0;
  localparam logic [CODE_W-1:0] CODE_EXTEND  = 8'hE0;
  localparam logic [CODE_W-1:0] CODE_ENTER   = 8'h5A;

  typedef struct packed {
    logic               hit;
    logic [DIGIT_W-1:0] value;
    logic               enter;
  } key_result_t;
endpackage

// File: rtl/kbd_prefix_tracker.sv
module kbd_prefix_tracker
  import kbd_digit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              byte_valid_i,
  input  logic [CODE_W-1:0] byte_i,
  output logic              report_o,
  output logic [CODE_W-1:0] code_o
);
  logic armed_q;
  logic is_release;
  logic is_extend;

  always_comb begin
    is_release = (byte_i == CODE_RELEASE);
    is_extend  = (byte_i == CODE_EXTEND);
    report_o   = byte_valid_i && armed_q && !is_release && !is_extend;
    code_o     = byte_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed_q <= 1'b0;
    end else if (byte_valid_i) begin
      if (is_release) begin
        armed_q <= 1'b1;
      end else if (!is_extend) begin
        // a reported key, or a make code, leaves nothing pending
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbd_code_mapper.sv
module kbd_code_mapper
  import kbd_digit_pkg::*;
#(
  parameter bit KEYPAD_EN = 1'b1
) (
  input  logic [CODE_W-1:0] code_i,
  output key_result_t       res_o
);
  logic [DIGIT_W-1:0] main_val;
  logic               main_hit;
  logic [DIGIT_W-1:0] pad_val;
  logic               pad_hit;

  always_comb begin
    main_hit = 1'b1;
    unique case (code_i)
      8'h45:   main_val = 4'd0;
      8'h16:   main_val = 4'd1;
      8'h1E:   main_val = 4'd2;
      8'h26:   main_val = 4'd3;
      8'h25:   main_val = 4'd4;
      8'h2E:   main_val = 4'd5;
      8'h36:   main_val = 4'd6;
      8'h3D:   main_val = 4'd7;
      8'h3E:   main_val = 4'd8;
      8'h46:   main_val = 4'd9;
      default: begin main_val = '0; main_hit = 1'b0; end
    endcase
  end

  generate
    if (KEYPAD_EN) begin : g_pad
      always_comb begin
        pad_hit = 1'b1;
        unique case (code_i)
          8'h70:   pad_val = 4'd0;
          8'h69:   pad_val = 4'd1;
          8'h72:   pad_val = 4'd2;
          8'h7A:   pad_val = 4'd3;
          8'h6B:   pad_val = 4'd4;
          8'h73:   pad_val = 4'd5;
          8'h74:   pad_val = 4'd6;
          8'h6C:   pad_val = 4'd7;
          8'h75:   pad_val = 4'd8;
          8'h7D:   pad_val = 4'd9;
          default: begin pad_val = '0; pad_hit = 1'b0; end
        endcase
      end
    end else begin : g_nopad
      assign pad_val = '0;
      assign pad_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    res_o.hit   = main_hit | pad_hit;
    res_o.value = main_hit ? main_val : (pad_hit ? pad_val : '0);
    res_o.enter = (code_i == CODE_ENTER);
  end
endmodule

// File: rtl/kbd_release_digit.sv
module kbd_release_digit
  import kbd_digit_pkg::*;
#(
  parameter bit KEYPAD_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               byte_valid_i,
  input  logic [CODE_W-1:0]  byte_i,
  output logic               done_o,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               enter_o
);
  logic              report;
  logic [CODE_W-1:0] code;
  key_result_t       res;

  kbd_prefix_tracker u_track (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .report_o     (report),
    .code_o       (code)
  );

  kbd_code_mapper #(.KEYPAD_EN(KEYPAD_EN)) u_map (
    .code_i (code),
    .res_o  (res)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      done_o  <= 1'b0;
      digit_o <= '0;
      enter_o <= 1'b0;
    end else begin
      done_o <= report;
      if (report) begin
        digit_o <= res.hit ? res.value : '0;
        enter_o <= res.enter;
      end
    end
  end
endmodule

// File: rtl/kbd_release_digit_chk.sv
module kbd_release_digit_chk
  import kbd_digit_pkg::*;
(
  input logic               clk_i,
  input logic               rst_i,
  input logic               byte_valid_i,
  input logic [CODE_W-1:0]  byte_i,
  input logic               done_o,
  input logic [DIGIT_W-1:0] digit_o,
  input logic               enter_o
);
  // R8
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R2
  done_follows_byte_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> ($past(byte_valid_i) && $past(byte_i) != CODE_RELEASE
                && $past(byte_i) != CODE_EXTEND));

  // R5
  enter_zero_digit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && enter_o) |-> (digit_o == '0));

  // R4
  digit_bcd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    digit_o <= 4'd9);

  // R9
  hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> ($stable(digit_o) && $stable(enter_o)));

  // R10
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (!done_o && digit_o == '0 && !enter_o));
endmodule

bind kbd_release_digit kbd_release_digit_chk u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .byte_valid_i (byte_valid_i),
  .byte_i       (byte_i),
  .done_o       (done_o),
  .digit_o      (digit_o),
  .enter_o      (enter_o)
);

// File: tb/kbd_release_digit_tb.sv
module kbd_release_digit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       bv;
  logic [7:0] bd;
  logic       done;
  logic [3:0] digit;
  logic       enter;

  int compared   = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  kbd_release_digit dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .byte_valid_i (bv),
    .byte_i       (bd),
    .done_o       (done),
    .digit_o      (digit),
    .enter_o      (enter)
  );

  task automatic check(input string req, input logic ed, input logic [3:0] eg,
                       input logic ee);
    compared++;
    if (done !== ed || digit !== eg || enter !== ee) begin
      mismatched++;
      $display("FAIL %s: got done=%b digit=%0d enter=%b, expected done=%b digit=%0d enter=%b",
               req, done, digit, enter, ed, eg, ee);
    end
  endtask

  // strobe one byte; on return it is the negedge after the capturing edge
  task automatic send(input logic [7:0] b);
    bv = 1'b1; bd = b;
    @(negedge clk);
    bv = 1'b0; bd = 8'h00;
  endtask

  task automatic release_key(input logic [7:0] c);
    send(8'hF0);
    send(c);
  endtask

  task automatic do_reset();
    rst = 1'b1; bv = 1'b0; bd = 8'h00;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R10 reset", 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_main_digits();
    logic [7:0] codes [10] = '{8'h45, 8'h16, 8'h1E, 8'h26, 8'h25,
                               8'h2E, 8'h36, 8'h3D, 8'h3E, 8'h46};
    for (int i = 0; i < 10; i++) begin
      release_key(codes[i]);
      check("R2 main digit", 1'b1, 4'(i), 1'b0);
      @(negedge clk);
      check("R8 pulse ends", 1'b0, 4'(i), 1'b0);
    end
  endtask

  task automatic t_pad_digits();
    logic [7:0] codes [10] = '{8'h70, 8'h69, 8'h72, 8'h7A, 8'h6B,
                               8'h73, 8'h74, 8'h6C, 8'h75, 8'h7D};
    for (int i = 9; i >= 0; i--) begin
      release_key(codes[i]);
      check("R3 keypad digit", 1'b1, 4'(i), 1'b0);
    end
  endtask

  task automatic t_repeats();
    release_key(8'h26);
    check("R2 digit 3", 1'b1, 4'd3, 1'b0);
    for (int i = 0; i < 4; i++) begin
      send(8'h2E);
      check("R1 make repeat ignored", 1'b0, 4'd3, 1'b0);
    end
    release_key(8'h2E);
    check("R2 digit 5 after repeats", 1'b1, 4'd5, 1'b0);
  endtask

  task automatic t_other_and_enter();
    release_key(8'h3E);
    check("R2 digit 8", 1'b1, 4'd8, 1'b0);
    release_key(8'h1C);
    check("R4 non-digit is zero", 1'b1, 4'd0, 1'b0);
    release_key(8'h5A);
    check("R5 enter", 1'b1, 4'd0, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R9 hold enter", 1'b0, 4'd0, 1'b1);
    release_key(8'h16);
    check("R9 enter clears with next key", 1'b1, 4'd1, 1'b0);
  endtask

  task automatic t_extended();
    send(8'hE0); send(8'hF0); send(8'h5A);
    check("R6 E0 F0 5A", 1'b1, 4'd0, 1'b1);
    send(8'hF0); send(8'hE0);
    check("R6 E0 after F0 no report", 1'b0, 4'd0, 1'b1);
    send(8'h5A);
    check("R6 F0 E0 5A", 1'b1, 4'd0, 1'b1);
    send(8'hE0); send(8'h5A);
    check("R6 E0 alone arms nothing", 1'b0, 4'd0, 1'b1);
  endtask

  task automatic t_pending_clears();
    release_key(8'h36);
    check("R2 digit 6", 1'b1, 4'd6, 1'b0);
    send(8'h36);
    check("R7 pending cleared", 1'b0, 4'd6, 1'b0);
    send(8'h46);
    check("R7 still idle", 1'b0, 4'd6, 1'b0);
  endtask

  task automatic t_reset_pending();
    release_key(8'h25);
    check("R2 digit 4", 1'b1, 4'd4, 1'b0);
    send(8'hF0);
    do_reset();
    check("R10 reset outputs", 1'b0, 4'd0, 1'b0);
    send(8'h1E);
    check("R10 pending dropped", 1'b0, 4'd0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; bv = 1'b0; bd = 8'h00;
    @(negedge clk);
    t_reset_state();
    t_main_digits();
    t_pad_digits();
    t_repeats();
    t_other_and_enter();
    t_extended();
    t_pending_clears();
    t_reset_pending();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule